// File: doc/BRIEF.md
# Byte-Lane Static Memory with Control Decoding

This block is a clocked, synthesizable model of a 16-bit static memory. It is driven by five active-low controls: chip select, write enable, output enable and one enable per byte lane. Each clock edge turns these controls into one of four access modes: standby, write, read, or read with outputs off. Each byte lane is written or read on its own. The block has no bidirectional pins. It presents a data-out bus and one output-enable flag per lane, and a pad ring or an integration wrapper can turn these into tri-state drivers.

After reset, which stands for the supply becoming stable, the array is locked for a fixed initialization time. That time is given in microseconds and converted to clock cycles through a clock-frequency parameter. During the lockout, writes are discarded and no lane is driven. When the count finishes, `ready` rises and normal operation begins. All controls are plain pins sampled on the rising clock edge. There is no valid/ready handshake, because a static memory accepts a new access on every cycle and never applies back-pressure. Read data and lane flags appear one clock after the controls and the address are sampled.

Top module: `byte_lane_sram`

## Requirements
- R1: When `cs_n` is 1 at a clock edge, both bits of `lane_oe` are 0 after that edge. No write takes place, whatever the values of the other controls.
- R2: When `cs_n` and `we_n` are both 0 at an edge and `ready` is 1, the write takes place. Both `lane_oe` bits are 0 after that edge, even when `oe_n` is 0.
- R3: During a write, lane 0 (data bits 7..0) is stored when `be_n[0]` is 0, and lane 1 (bits 15..8) is stored when `be_n[1]` is 0. A lane whose enable is 1 keeps its stored byte.
- R4: When `cs_n` is 0, `we_n` is 1, `oe_n` is 0 and `ready` is 1 at an edge, `lane_oe[i]` is 1 after that edge exactly when `be_n[i]` was 0. The lane then shows the stored byte of the sampled address.
- R5: A read with `oe_n` at 1, or a read with both `be_n` bits at 1, leaves both `lane_oe` bits at 0 after the edge (outputs off).
- R6: Each byte of `dout` is zero whenever its `lane_oe` bit is 0.
- R7: While `ready` is 0, writes are discarded and both `lane_oe` bits stay 0. The memory contents are not cleared by reset.
- R8: `ready` is 0 during reset. It rises after exactly INIT_US*CLK_MHZ clock edges following the release of reset (15000 by default), and stays at 1 until the next reset.
- R9: A read on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; its release marks a stable supply |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| be_n | input | 2 | Byte-lane enables, active low; bit 0 covers data bits 7..0 |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; a byte is zero where its lane is not driven |
| lane_oe | output | 2 | Per-lane drive flag, bit i for byte i |
| ready | output | 1 | Initialization complete |

## Verification
The hardest case to reach from the ports is a write that is discarded during the lockout. A discarded write can only be seen against contents that were already known, and known contents can only be written after `ready` has risen. The stimulus therefore writes a known word once the block is ready, then applies reset a second time to re-enter the lockout. During this second lockout it attempts to overwrite that word. After `ready` rises again, it reads the word back and expects the value written before the second reset. The same pass counts edges so that `ready` is sampled one edge before the end of the count and again on the final edge.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_STORE   = 2'd1,
    MODE_FETCH   = 2'd2,
    MODE_FETCH_Q = 2'd3
  } access_mode_e;

  function automatic access_mode_e classify(
    input logic sel_n,
    input logic wr_n,
    input logic out_n,
    input logic all_lanes_off
  );
    if (sel_n)                     return MODE_IDLE;
    else if (!wr_n)                return MODE_STORE;
    else if (out_n || all_lanes_off) return MODE_FETCH_Q;
    else                           return MODE_FETCH;
  endfunction

endpackage

// File: rtl/bls_init_timer.sv
module bls_init_timer #(
  parameter int INIT_US = 150,
  parameter int CLK_MHZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int INIT_CYCLES = INIT_US * CLK_MHZ;
  localparam int CNT_W       = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == LAST) ready_q <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready = ready_q;

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

  p_ready_at_count_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  input  logic             ready,
  output access_mode_e     mode,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane,
  output logic             fetch_any
);
  always_comb begin
    mode      = classify(cs_n, we_n, oe_n, &be_n);
    fetch_any = (mode == MODE_FETCH) || (mode == MODE_FETCH_Q);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_lane[g] = (mode == MODE_STORE) && ready && !be_n[g];
    assign rd_lane[g] = (mode == MODE_FETCH) && ready && !be_n[g];
  end

  always_comb begin
    if (!ready) a_locked_no_write_r7: assert (wr_lane == '0);
    if (cs_n)   a_standby_no_write_r1: assert (wr_lane == '0);
  end

endmodule

// File: rtl/bls_lane_bank.sv
module bls_lane_bank #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic                    fetch,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (fetch)      rd_q        <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int INIT_US = 150,
  parameter int CLK_MHZ = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [1:0]        be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        lane_oe,
  output logic              ready
);
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  access_mode_e      mode;
  logic [LANES-1:0]  wr_lane, rd_lane;
  logic              fetch_any;
  logic [DATA_W-1:0] rdata;
  logic [LANES-1:0]  oe_q;

  bls_init_timer #(.INIT_US(INIT_US), .CLK_MHZ(CLK_MHZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .ready(ready)
  );

  bls_decode #(.LANES(LANES)) u_decode (
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n), .ready(ready),
    .mode(mode), .wr_lane(wr_lane), .rd_lane(rd_lane), .fetch_any(fetch_any)
  );

  bls_lane_bank #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .addr(addr), .wr_lane(wr_lane), .fetch(fetch_any),
    .wdata(din), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= '0;
    else        oe_q <= rd_lane;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dout[g*LANE_W +: LANE_W] = oe_q[g] ? rdata[g*LANE_W +: LANE_W] : '0;
  end

  assign lane_oe = oe_q;

  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (lane_oe == '0));

  p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (lane_oe == '0));

  p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n && ready) |=> (lane_oe == ~$past(be_n)));

  p_out_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && oe_n) |=> (lane_oe == '0));

  p_locked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (lane_oe == '0));

endmodule

// File: tb/byte_lane_sram_tb.sv
module byte_lane_sram_tb;
  localparam int INIT_CYCLES = 150 * 100;

  typedef struct packed {
    logic        cs_n;
    logic        we_n;
    logic        oe_n;
    logic [1:0]  be_n;
    logic [3:0]  addr;
    logic [15:0] din;
    logic [1:0]  exp_oe;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,2'b00,4'd0,16'h1A2B,2'b00}, // R2 full write
    '{1'b0,1'b0,1'b1,2'b00,4'd1,16'h3C4D,2'b00}, // R2
    '{1'b0,1'b0,1'b0,2'b00,4'd2,16'h5E6F,2'b00}, // R2 write with oe low
    '{1'b0,1'b1,1'b0,2'b00,4'd0,16'h0000,2'b11}, // R4
    '{1'b0,1'b0,1'b1,2'b10,4'd0,16'hFFEE,2'b00}, // R3 lower only
    '{1'b0,1'b1,1'b0,2'b00,4'd0,16'h0000,2'b11}, // R3
    '{1'b0,1'b0,1'b1,2'b01,4'd1,16'h99AA,2'b00}, // R3 upper only
    '{1'b0,1'b1,1'b0,2'b10,4'd1,16'h0000,2'b01}, // R4 R6 lower lane
    '{1'b0,1'b1,1'b0,2'b01,4'd1,16'h0000,2'b10}, // R4 R6 upper lane
    '{1'b0,1'b1,1'b1,2'b00,4'd2,16'h0000,2'b00}, // R5 oe high
    '{1'b0,1'b1,1'b0,2'b11,4'd2,16'h0000,2'b00}, // R5 no lanes
    '{1'b1,1'b0,1'b0,2'b00,4'd2,16'h0000,2'b00}, // R1 standby write
    '{1'b0,1'b1,1'b0,2'b00,4'd2,16'h0000,2'b11}, // R1 data kept
    '{1'b1,1'b1,1'b0,2'b00,4'd2,16'h0000,2'b00}, // R1 standby read
    '{1'b0,1'b0,1'b1,2'b11,4'd3,16'h7777,2'b00}, // R3 no lane write
    '{1'b0,1'b0,1'b1,2'b00,4'd3,16'h0102,2'b00}, // R2
    '{1'b0,1'b1,1'b0,2'b00,4'd3,16'h0000,2'b11}, // R9
    '{1'b0,1'b0,1'b0,2'b11,4'd3,16'hFFFF,2'b00}, // R3
    '{1'b0,1'b1,1'b0,2'b00,4'd3,16'h0000,2'b11}, // R3
    '{1'b0,1'b0,1'b1,2'b00,4'd4,16'h4455,2'b00}, // R9
    '{1'b0,1'b1,1'b0,2'b00,4'd4,16'h0000,2'b11}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  be_n = 2'b11;
  logic [9:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  lane_oe;
  logic        ready;

  int tests = 0;
  int fails = 0;
  int edge_cnt = 0;
  logic [15:0] ref_mem [16];

  always #5 clk = ~clk;

  byte_lane_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .din(din), .dout(dout), .lane_oe(lane_oe),
    .ready(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    edge_cnt++;
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic w, input logic o,
                       input logic [1:0] b, input logic [9:0] a, input logic [15:0] d);
    cs_n = c; we_n = w; oe_n = o; be_n = b; addr = a; din = d;
  endtask

  task automatic wait_ready(input string tag);
    while (edge_cnt < INIT_CYCLES - 1) tick();
    check({tag, " ready low one edge early"}, {31'd0, ready}, 32'd0);
    tick();
    check({tag, " ready high at count end"}, {31'd0, ready}, 32'd1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] exp_d;
    repeat (3) @(negedge clk);
    check("R8 ready low in reset", {31'd0, ready}, 32'd0);
    check("R1 lane_oe low in reset", {30'd0, lane_oe}, 32'd0);
    check("R6 dout zero in reset", {16'd0, dout}, 32'd0);

    rst_n = 1'b1;
    edge_cnt = 0;
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'd0, 16'h0);
    tick();
    check("R7 no drive while locked", {30'd0, lane_oe}, 32'd0);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 10'd0, 16'h0);
    wait_ready("R8");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cs_n, VECS[i].we_n, VECS[i].oe_n, VECS[i].be_n,
            {6'd0, VECS[i].addr}, VECS[i].din);
      if (!VECS[i].cs_n && !VECS[i].we_n) begin
        if (!VECS[i].be_n[0]) ref_mem[VECS[i].addr][7:0]  = VECS[i].din[7:0];
        if (!VECS[i].be_n[1]) ref_mem[VECS[i].addr][15:8] = VECS[i].din[15:8];
      end
      exp_d = {VECS[i].exp_oe[1] ? ref_mem[VECS[i].addr][15:8] : 8'h00,
               VECS[i].exp_oe[0] ? ref_mem[VECS[i].addr][7:0]  : 8'h00};
      tick();
      check($sformatf("R1-5 vec %0d lane_oe", i), {30'd0, lane_oe}, {30'd0, VECS[i].exp_oe});
      check($sformatf("R3/R4/R6/R9 vec %0d dout", i), {16'd0, dout}, {16'd0, exp_d});
    end

    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'd9, 16'h1111);
    tick();
    drive(1'b1, 1'b1, 1'b1, 2'b11, 10'd0, 16'h0);
    rst_n = 1'b0;
    tick();
    check("R8 ready cleared by reset", {31'd0, ready}, 32'd0);
    rst_n = 1'b1;
    edge_cnt = 0;
    drive(1'b0, 1'b0, 1'b0, 2'b00, 10'd9, 16'hDEAD);
    tick();
    check("R7 lane_oe low on locked write", {30'd0, lane_oe}, 32'd0);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 10'd0, 16'h0);
    wait_ready("R8 second");
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'd9, 16'h0);
    tick();
    check("R7 locked write discarded", {16'd0, dout}, 32'h0000_1111);
    check("R7 lane_oe after ready", {30'd0, lane_oe}, 32'd3);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 10'd0, 16'h0);
    tick();
    check("R1 idle after read", {30'd0, lane_oe}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule